// File: doc/BRIEF.md
# Transmit Line Error Injector

This block sits on the transmit path between the framer and the line driver. It takes one unipolar bit per clock and encodes it as alternate mark inversion on two rails, one positive and one negative. On request it corrupts the stream in one of three ways. It can emit a line code violation, which is a mark with the same polarity as the mark before it. It can invert the bit sent in the next frame-bit slot. It can invert the bit sent in the next CRC-bit slot.

Software or a test sequencer raises a request as a pulse one clock wide. The request is held as a pending flag until a bit position that can carry that error comes along. The error is applied there exactly once and the flag then clears by itself. The three kinds of request are independent of each other and can be pending or applied in the same cycle. In T1 mode a violation needs two marks in a row and is placed on the second one. In E1 mode a violation is a pair: the next two marks both repeat the polarity of the mark before them.

Top module: `txerr_inject`

## Requirements
- R1: After reset both rails and all three pending flags are low. The first mark sent after reset is on the positive rail (linePos=1).
- R2: The rail outputs are registered and appear on the clock after their input bit. A mark drives exactly one rail high, with polarity alternating from mark to mark. A zero drives both rails low, and both rails are never high at the same time.
- R3: A one on a request input sets the matching pending flag on the next clock. A zero on a request input leaves the pending flags and the line output unchanged.
- R4: A request that arrives while the same error is already pending merges with it, so only one error is produced.
- R5: While a frame error is pending, the bit in the next cycle with frameSlot=1 is inverted before encoding. The flag clears on that clock and later frame slots are sent unchanged.
- R6: While a CRC error is pending, the bit in the next cycle with crcSlot=1 is inverted before encoding. The flag clears on that clock and later CRC slots are sent unchanged.
- R7: In T1 mode (e1Mode=0), a pending violation is placed only on a mark whose preceding bit was also a mark. That mark repeats the previous mark's polarity, and the flag then clears. Isolated marks leave the request pending.
- R8: In E1 mode (e1Mode=1), a pending violation makes the next two marks, consecutive or not, both repeat the polarity of the last mark sent before them. The flag clears after the second of these marks.
- R9: After a violating mark, alternation resumes from that mark's polarity, so the following mark has the opposite polarity.
- R10: Violation, frame and CRC requests pending at the same time are each applied at their own eligible position without disturbing one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txBit | input | 1 | Unipolar transmit bit for this cycle |
| frameSlot | input | 1 | Current bit is a frame bit |
| crcSlot | input | 1 | Current bit is a CRC bit |
| e1Mode | input | 1 | 1 selects E1 violation pairs, 0 selects T1 |
| reqLcv | input | 1 | One-cycle line code violation request |
| reqFrame | input | 1 | One-cycle frame bit error request |
| reqCrc | input | 1 | One-cycle CRC bit error request |
| linePos | output | 1 | Positive line rail |
| lineNeg | output | 1 | Negative line rail |
| pendLcv | output | 1 | Violation request waiting or in progress |
| pendFrame | output | 1 | Frame error request waiting |
| pendCrc | output | 1 | CRC error request waiting |

## Verification
The embedded properties assume that frameSlot and crcSlot are never high in the same cycle. They also assume that e1Mode does not change while a violation is pending or only half applied, and that every request is a single-cycle pulse. The stimulus places frame slots and CRC slots at different phases of an eight-bit cycle. It switches the mode only when the reference model shows no violation outstanding, and it clears every request on the clock after raising it. Bit patterns include all zeros, all ones, isolated marks and a pseudo-random sequence, so that pending requests are seen both waiting and being applied.

// File: rtl/txerr_pkg.sv
package txerr_pkg;
  // Strobes from control to datapath for one bit period
  typedef struct packed {
    logic mark;     // encoded bit after any frame/CRC inversion
    logic violate;  // send this mark with the previous polarity
  } lineStrobe_t;
endpackage

// File: rtl/txerr_ctrl.sv
module txerr_ctrl
  import txerr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txBit,
  input  logic        frameSlot,
  input  logic        crcSlot,
  input  logic        e1Mode,
  input  logic        reqLcv,
  input  logic        reqFrame,
  input  logic        reqCrc,
  input  logic        prevMark,
  output lineStrobe_t strobe,
  output logic        pendLcv,
  output logic        pendFrame,
  output logic        pendCrc
);
  logic frameHit, crcHit, lcvFirstDone, lcvFinish;

  assign frameHit = frameSlot && pendFrame;
  assign crcHit   = crcSlot && pendCrc;

  always_comb begin
    strobe.mark    = txBit ^ (frameHit | crcHit);
    strobe.violate = pendLcv && strobe.mark && (e1Mode || prevMark);
  end

  assign lcvFinish = strobe.violate && (!e1Mode || lcvFirstDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFrame    <= 1'b0;
      pendCrc      <= 1'b0;
      pendLcv      <= 1'b0;
      lcvFirstDone <= 1'b0;
    end else begin
      pendFrame <= frameHit ? 1'b0 : (pendFrame | reqFrame);
      pendCrc   <= crcHit   ? 1'b0 : (pendCrc | reqCrc);
      if (lcvFinish) begin
        pendLcv      <= 1'b0;
        lcvFirstDone <= 1'b0;
      end else if (strobe.violate) begin
        lcvFirstDone <= 1'b1;
      end else begin
        pendLcv <= pendLcv | reqLcv;
      end
    end
  end

  p_req_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqFrame && !frameHit) |=> pendFrame);
  p_frame_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameHit |=> !pendFrame);
  p_crc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcHit |=> !pendCrc);
  p_t1_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.violate && !e1Mode) |-> prevMark);
  p_slots_apart_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(frameSlot && crcSlot));
endmodule

// File: rtl/txerr_line.sv
module txerr_line
  import txerr_pkg::*;
#(
  parameter bit FIRST_MARK_POS = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineStrobe_t strobe,
  output logic        prevMark,
  output logic        linePos,
  output logic        lineNeg
);
  logic lastPol;  // 1 when the last mark went out positive
  logic nextPol;

  assign nextPol = strobe.violate ? lastPol : !lastPol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPol  <= !FIRST_MARK_POS;
      prevMark <= 1'b0;
      linePos  <= 1'b0;
      lineNeg  <= 1'b0;
    end else begin
      prevMark <= strobe.mark;
      if (strobe.mark) begin
        linePos <= nextPol;
        lineNeg <= !nextPol;
        lastPol <= nextPol;
      end else begin
        linePos <= 1'b0;
        lineNeg <= 1'b0;
      end
    end
  end

  p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(linePos && lineNeg));
  p_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.mark |=> (!linePos && !lineNeg));
  p_same_pol_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mark && strobe.violate) |=> (linePos == $past(lastPol)));
  p_alternate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mark && !strobe.violate) |=> (linePos != $past(lastPol)));
endmodule

// File: rtl/txerr_inject.sv
module txerr_inject
  import txerr_pkg::*;
#(
  parameter bit FIRST_MARK_POS = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic txBit,
  input  logic frameSlot,
  input  logic crcSlot,
  input  logic e1Mode,
  input  logic reqLcv,
  input  logic reqFrame,
  input  logic reqCrc,
  output logic linePos,
  output logic lineNeg,
  output logic pendLcv,
  output logic pendFrame,
  output logic pendCrc
);
  lineStrobe_t strobe;
  logic        prevMark;

  txerr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txBit(txBit), .frameSlot(frameSlot),
    .crcSlot(crcSlot), .e1Mode(e1Mode), .reqLcv(reqLcv),
    .reqFrame(reqFrame), .reqCrc(reqCrc), .prevMark(prevMark),
    .strobe(strobe), .pendLcv(pendLcv), .pendFrame(pendFrame),
    .pendCrc(pendCrc)
  );

  txerr_line #(.FIRST_MARK_POS(FIRST_MARK_POS)) u_line (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prevMark(prevMark),
    .linePos(linePos), .lineNeg(lineNeg)
  );
endmodule

// File: tb/txerr_inject_test.sv
module txerr_inject_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic txBit = 0, frameSlot = 0, crcSlot = 0, e1Mode = 0;
  logic reqLcv = 0, reqFrame = 0, reqCrc = 0;
  logic linePos, lineNeg, pendLcv, pendFrame, pendCrc;

  txerr_inject uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int phase = 0, patMode = 0;
  int lfsr = 32'h1ACE;
  string curReq = "R1";
  // reference model state
  bit mL = 0, mF = 0, mC = 0, mHalf = 0, mLast = 0, mPrev = 0;
  bit eP = 0, eN = 0;
  bit done = 0;

  function automatic bit nextBit();
    bit b;
    case (patMode)
      1: b = 1'b1;
      2: b = 1'b0;
      3: b = phase[0];
      default: begin
        b = lfsr[0];
        lfsr = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? 32'h80200003 : 32'h0);
      end
    endcase
    return b;
  endfunction

  task automatic compare();
    checks++;
    if ({linePos, lineNeg, pendLcv, pendFrame, pendCrc} !== {eP, eN, mL, mF, mC}) begin
      fails++;
      $display("FAIL %s t=%0t actual pos/neg/pl/pf/pc=%b%b%b%b%b expected=%b%b%b%b%b",
        curReq, $time, linePos, lineNeg, pendLcv, pendFrame, pendCrc, eP, eN, mL, mF, mC);
    end
  endtask

  task automatic tick(input bit rl, input bit rf, input bit rc);
    bit inv, mark, viol, pol;
    reqLcv = rl; reqFrame = rf; reqCrc = rc;
    txBit = nextBit();
    frameSlot = (phase % 8 == 0);
    crcSlot = (phase % 8 == 4);
    @(posedge clk); #1;
    inv  = (frameSlot && mF) || (crcSlot && mC);
    mark = txBit ^ inv;
    viol = mL && mark && (e1Mode || mPrev);
    pol  = viol ? mLast : !mLast;
    if (mark) begin eP = pol; eN = !pol; mLast = pol; end
    else begin eP = 0; eN = 0; end
    mPrev = mark;
    if (frameSlot && mF) mF = 0; else mF = mF | rf;
    if (crcSlot && mC) mC = 0; else mC = mC | rc;
    if (viol) begin
      if (e1Mode && !mHalf) mHalf = 1;
      else begin mL = 0; mHalf = 0; end
    end else mL = mL | rl;
    compare();
    reqLcv = 0; reqFrame = 0; reqCrc = 0;
    phase++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R1"; compare();
    patMode = 1; tick(0, 0, 0);  // R1: first mark positive
    curReq = "R2"; patMode = 0; run(24);
    patMode = 2; run(6);
    curReq = "R3"; patMode = 0; run(5); tick(0, 1, 0); run(1);
    curReq = "R5"; run(12);
    curReq = "R4"; tick(0, 1, 0); tick(0, 1, 0); run(12);
    curReq = "R6"; tick(0, 0, 1); run(12);
    curReq = "R7"; patMode = 2; tick(1, 0, 0); run(4);
    patMode = 3; run(8);
    patMode = 1; run(6);
    curReq = "R9"; run(6);
    patMode = 0; run(10);
    curReq = "R8"; e1Mode = 1; patMode = 2; tick(1, 0, 0); run(3);
    patMode = 3; run(8);
    patMode = 1; run(6);
    patMode = 0; tick(1, 0, 0); run(20);
    curReq = "R10"; tick(1, 1, 1); run(20);
    e1Mode = 0; patMode = 0; tick(1, 1, 1); run(30);
    for (int k = 0; k < 40; k++) begin
      tick(k % 5 == 0, k % 7 == 0, k % 3 == 0);
      if (!mL && !mHalf && k % 11 == 0) e1Mode = ~e1Mode;
    end
    run(30);
    finishRun();
  end
endmodule